// File: doc/BRIEF.md
# Strap-Configured Audio Bit and Frame Clock Generator

This block drives the bit clock and frame clock of a serial audio port when the port acts as clock master. After reset is released it leaves both clock pads undriven for a fixed power-up window. During that window the two pads are read as configuration straps. Each pad has a weak pull-down by default, and a board can fit an external pull-up instead. The frame-clock pad strap selects single or double speed. The bit-clock pad strap selects the higher or lower master-clock ratio.

On the final cycle of the window the straps are latched. On the following cycle both pads become outputs. The bit clock is then produced by dividing the master clock by 2, 3, 4 or 6, always at 50% duty. The frame clock toggles on every 32nd falling edge of the bit clock, so one frame holds 64 bit clocks. The latched speed and ratio are driven out for the datapath. A generate-time pre-divider option doubles every divisor, which gives 512x/768x in single speed and 256x/384x in double speed.

Top module: `mclk_strap_clkgen`

## Requirements
- R1: While reset is asserted, and afterwards until the pads are enabled, both pad output enables are 0 and both pad output values are 0. In reset, dbl_speed_o is 0 and ratio_o is 2 (256x).
- R2: The pad output enables stay 0 through the first PWRUP_CYCLES (default 4096) rising master-clock edges after reset release. Both go to 1 right after edge number PWRUP_CYCLES and stay at 1 until the next reset.
- R3: The straps are taken only from the pad input values sampled at edge number PWRUP_CYCLES. Earlier values have no effect. Pad input changes after that edge change neither dbl_speed_o, ratio_o, nor the clock periods.
- R4: The configuration encoding is ratio_o = {~lrck strap, sclk strap}: 0 = 128x, 1 = 192x, 2 = 256x, 3 = 384x. dbl_speed_o equals the latched lrck strap.
- R5: With the default PREDIV=1, the bit clock period is 2, 4 or 6 master-clock periods for 128x, 256x and 384x. The high phase is exactly half the period.
- R6: For 192x, the bit clock period is 3 master-clock periods. The high and low phases are each 1.5 master-clock periods.
- R7: The frame-clock period is 64 bit-clock periods, which is 64 times the bit-clock divisor in master-clock periods. Each frame-clock level lasts exactly 32 bit-clock falling edges.
- R8: Every frame-clock transition coincides with a bit-clock falling edge.
- R9: When the pads are enabled, the frame clock starts low. The bit clock rises one master-clock period later. The frame clock first rises on the 32nd bit-clock falling edge.
- R10: Asserting reset while the clocks run immediately returns the pads to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_pad_i | input | 1 | Bit-clock pad input value (ratio strap) |
| lrck_pad_i | input | 1 | Frame-clock pad input value (speed strap) |
| sclk_pad_o | output | 1 | Bit-clock pad output value |
| sclk_pad_oe_o | output | 1 | Bit-clock pad output enable |
| lrck_pad_o | output | 1 | Frame-clock pad output value |
| lrck_pad_oe_o | output | 1 | Frame-clock pad output enable |
| dbl_speed_o | output | 1 | Latched speed mode, 1 = double speed |
| ratio_o | output | 2 | Latched master-clock/frame ratio code |

## Verification
A window counter that is off by one shows up as the output enable rising one edge early or late. It can also latch a strap value driven one cycle away from the sampling edge, and either fault is visible at the very edge where enable is expected. A wrong divisor or a lost negative-edge phase shows up in the first bit-clock period, as a wrong period or a 1:2 duty instead of 1.5:1.5. A frame counter that slips shows up by the 32nd bit-clock fall, as a frame edge that is misplaced or does not land on a bit-clock fall. A frame period that is not 64 bit clocks is seen within one frame.

// File: rtl/mclkgen_pkg.sv
`timescale 1ns/1ps
package mclkgen_pkg;

  typedef enum logic [1:0] {
    RATIO_128 = 2'd0,
    RATIO_192 = 2'd1,
    RATIO_256 = 2'd2,
    RATIO_384 = 2'd3
  } ratio_e;

  function automatic ratio_e ratio_of(input logic dbl, input logic hi);
    return ratio_e'({~dbl, hi});
  endfunction

  function automatic int unsigned base_div(input ratio_e r);
    case (r)
      RATIO_128: return 2;
      RATIO_192: return 3;
      RATIO_256: return 4;
      default:   return 6;
    endcase
  endfunction

endpackage

// File: rtl/strap_sampler.sv
`timescale 1ns/1ps
module strap_sampler #(
  parameter int unsigned PWRUP_CYCLES = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lrck_strap_i,
  input  logic sclk_strap_i,
  output logic done_o,
  output logic dbl_o,
  output logic hi_o
);
  localparam int unsigned CW = $clog2(PWRUP_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(PWRUP_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
      dbl_o  <= 1'b0;
      hi_o   <= 1'b0;
    end else if (!done_o) begin
      if (cnt_q == LAST) begin
        done_o <= 1'b1;
        dbl_o  <= lrck_strap_i;
        hi_o   <= sclk_strap_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(done_o)) |-> ($stable(dbl_o) && $stable(hi_o))); // R3

endmodule

// File: rtl/sclk_divider.sv
`timescale 1ns/1ps
module sclk_divider #(
  parameter int unsigned DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [DW-1:0] div_i,
  output logic          sclk_o,
  output logic          fall_o,
  output logic          odd_o
);
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] half;
  logic          pos_q, neg_q, hi_next;

  assign half    = div_i >> 1;
  assign hi_next = cnt_q < half;
  assign odd_o   = div_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pos_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      pos_q <= 1'b0;
    end else begin
      pos_q <= hi_next;
      cnt_q <= (cnt_q == div_i - 1'b1) ? '0 : cnt_q + 1'b1;
    end
  end

  // half-cycle stretch for odd divisors
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= 1'b0;
    else         neg_q <= pos_q;
  end

  assign sclk_o = pos_q | (odd_o & neg_q);
  assign fall_o = run_i & pos_q & ~hi_next;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < div_i)); // R5
  AST_DIV_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |-> $stable(div_i)); // R3

endmodule

// File: rtl/lrck_framer.sv
`timescale 1ns/1ps
module lrck_framer #(
  parameter int unsigned HALF_SCLKS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic fall_i,
  input  logic odd_i,
  output logic lrck_o
);
  localparam int unsigned BW = (HALF_SCLKS > 1) ? $clog2(HALF_SCLKS) : 1;
  localparam logic [BW-1:0] LAST = BW'(HALF_SCLKS - 1);

  logic [BW-1:0] bcnt_q;
  logic          lp_q, ln_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcnt_q <= '0;
      lp_q   <= 1'b0;
    end else if (!run_i) begin
      bcnt_q <= '0;
      lp_q   <= 1'b0;
    end else if (fall_i) begin
      if (bcnt_q == LAST) begin
        bcnt_q <= '0;
        lp_q   <= ~lp_q;
      end else begin
        bcnt_q <= bcnt_q + 1'b1;
      end
    end
  end

  // follows the bit clock fall, which lands on a negedge for odd divisors
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ln_q <= 1'b0;
    else         ln_q <= lp_q;
  end

  assign lrck_o = odd_i ? ln_q : lp_q;

  AST_LRCK_ON_SCLK_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && (lp_q != $past(lp_q))) |-> $past(fall_i)); // R8

endmodule

// File: rtl/mclk_strap_clkgen.sv
`timescale 1ns/1ps
module mclk_strap_clkgen
  import mclkgen_pkg::*;
#(
  parameter int unsigned PWRUP_CYCLES = 4096,
  parameter int unsigned PREDIV       = 1,
  parameter int unsigned HALF_SCLKS   = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_pad_i,
  input  logic       lrck_pad_i,
  output logic       sclk_pad_o,
  output logic       sclk_pad_oe_o,
  output logic       lrck_pad_o,
  output logic       lrck_pad_oe_o,
  output logic       dbl_speed_o,
  output logic [1:0] ratio_o
);
  localparam int unsigned DW = $clog2(6 * PREDIV + 1);

  logic          run, dbl, hi, fall, odd;
  ratio_e        ratio;
  logic [DW-1:0] div;

  strap_sampler #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_straps (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lrck_strap_i (lrck_pad_i),
    .sclk_strap_i (sclk_pad_i),
    .done_o       (run),
    .dbl_o        (dbl),
    .hi_o         (hi)
  );

  assign ratio = ratio_of(dbl, hi);

  generate
    if (PREDIV == 2) begin : g_prediv
      assign div = DW'(base_div(ratio) * 2);
    end else begin : g_direct
      assign div = DW'(base_div(ratio));
    end
  endgenerate

  sclk_divider #(.DW(DW)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (div),
    .sclk_o (sclk_pad_o),
    .fall_o (fall),
    .odd_o  (odd)
  );

  lrck_framer #(.HALF_SCLKS(HALF_SCLKS)) u_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .fall_i (fall),
    .odd_i  (odd),
    .lrck_o (lrck_pad_o)
  );

  assign sclk_pad_oe_o = run;
  assign lrck_pad_oe_o = run;
  assign dbl_speed_o   = dbl;
  assign ratio_o       = ratio;

  AST_PADS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_pad_oe_o |-> (!sclk_pad_o && !lrck_pad_o)); // R1

endmodule

// File: tb/mclk_strap_clkgen_tb_top.sv
`timescale 1ns/100ps
module mclk_strap_clkgen_tb_top;
  localparam int PW = 4096;
  localparam real TCK = 4.0;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk_pad_i = 1'b0;
  logic lrck_pad_i = 1'b0;
  logic sclk_pad_o, sclk_pad_oe_o, lrck_pad_o, lrck_pad_oe_o, dbl_speed_o;
  logic [1:0] ratio_o;

  int errors = 0;
  int checks = 0;

  always #(TCK / 2) clk_i = ~clk_i;

  mclk_strap_clkgen #(.PWRUP_CYCLES(PW)) dut_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sclk_pad_i    (sclk_pad_i),
    .lrck_pad_i    (lrck_pad_i),
    .sclk_pad_o    (sclk_pad_o),
    .sclk_pad_oe_o (sclk_pad_oe_o),
    .lrck_pad_o    (lrck_pad_o),
    .lrck_pad_oe_o (lrck_pad_oe_o),
    .dbl_speed_o   (dbl_speed_o),
    .ratio_o       (ratio_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one power-up and run scenario per strap setting
  task automatic run_case(input bit dbl, input bit hi, input bit mid_reset);
    int n, code, falls;
    bit ok;
    real t0, t1, t2;
    n    = dbl ? (hi ? 3 : 2) : (hi ? 6 : 4);
    code = {~dbl, hi};
    rst_ni = 1'b0;
    lrck_pad_i = ~dbl;
    sclk_pad_i = ~hi;
    repeat (3) @(posedge clk_i);
    #1;
    chk(!sclk_pad_oe_o && !lrck_pad_oe_o && !sclk_pad_o && !lrck_pad_o, "R1",
        "pads in reset", {sclk_pad_oe_o, lrck_pad_oe_o, sclk_pad_o, lrck_pad_o}, 0);
    chk(ratio_o == 2'd2 && !dbl_speed_o, "R1", "cfg in reset", {dbl_speed_o, ratio_o}, 2);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (PW - 1) @(posedge clk_i);
    #1;
    chk(!sclk_pad_oe_o && !lrck_pad_oe_o && !sclk_pad_o && !lrck_pad_o, "R2",
        "pads before last window edge", {sclk_pad_oe_o, lrck_pad_oe_o}, 0);
    lrck_pad_i = dbl;
    sclk_pad_i = hi;
    @(posedge clk_i);
    #1;
    chk(sclk_pad_oe_o && lrck_pad_oe_o, "R2", "oe after window",
        {sclk_pad_oe_o, lrck_pad_oe_o}, 3);
    chk(ratio_o == code[1:0], "R4", "ratio code", ratio_o, code);
    chk(dbl_speed_o == dbl, "R4", "speed", dbl_speed_o, dbl);
    lrck_pad_i = ~dbl;
    sclk_pad_i = ~hi;
    chk(!lrck_pad_o && !sclk_pad_o, "R9", "initial lrck/sclk low",
        {lrck_pad_o, sclk_pad_o}, 0);
    ok = 1'b1;
    for (int i = 1; i <= 32; i++) begin
      @(negedge sclk_pad_o);
      #0.5;
      if (lrck_pad_o != (i == 32)) ok = 1'b0;
    end
    chk(ok, "R7", "lrck rises on 32nd sclk fall (R9 R8)", lrck_pad_o, 1);
    @(posedge sclk_pad_o); t0 = $realtime;
    @(negedge sclk_pad_o); t1 = $realtime;
    @(posedge sclk_pad_o); t2 = $realtime;
    if (n == 3) begin
      chk(int'((t2 - t0) * 10) == 120, "R6", "sclk period x0.1ns", int'((t2 - t0) * 10), 120);
      chk(int'((t1 - t0) * 10) == 60, "R6", "sclk high x0.1ns", int'((t1 - t0) * 10), 60);
    end else begin
      chk(int'(t2 - t0) == n * 4, "R5", "sclk period ns", int'(t2 - t0), n * 4);
      chk(int'((t1 - t0) * 2) == n * 4, "R5", "sclk high x2 ns", int'((t1 - t0) * 2), n * 4);
    end
    @(negedge lrck_pad_o); t0 = $realtime;
    #0.5;
    chk(!sclk_pad_o, "R8", "sclk low at lrck fall", sclk_pad_o, 0);
    falls = 0;
    fork
      begin
        @(negedge lrck_pad_o);
      end
      begin
        forever begin
          @(negedge sclk_pad_o);
          falls++;
        end
      end
    join_any
    disable fork;
    t1 = $realtime;
    chk(falls == 64, "R7", "sclk falls per frame", falls, 64);
    chk(int'(t1 - t0) == 64 * n * 4, "R7", "lrck period ns", int'(t1 - t0), 64 * n * 4);
    chk(ratio_o == code[1:0] && dbl_speed_o == dbl, "R3", "cfg after pad change",
        {dbl_speed_o, ratio_o}, {dbl, code[1:0]});
    if (mid_reset) begin
      @(negedge clk_i);
      #0.7;
      rst_ni = 1'b0;
      #0.2;
      chk(!sclk_pad_oe_o && !lrck_pad_oe_o && !sclk_pad_o && !lrck_pad_o, "R10",
          "pads after running reset", {sclk_pad_oe_o, lrck_pad_oe_o, sclk_pad_o, lrck_pad_o}, 0);
    end
  endtask

  initial begin
    #(150000 * TCK);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    run_case(1'b0, 1'b0, 1'b0);
    run_case(1'b0, 1'b1, 1'b0);
    run_case(1'b1, 1'b0, 1'b0);
    run_case(1'b1, 1'b1, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule